// File: doc/BRIEF.md
# Opcode-Stream Shadow Register Tracker

This block sits beside a Z80-style processor whose I/O strobe and data pins cannot be observed during I/O cycles. It watches only the memory-request strobe, the write strobe and the address bus. It decides which memory reads are opcode fetches and looks up the fetched bytes through read ports into the memory it serves. From a fixed subset of instructions it keeps shadow copies of the A, B, C, H and L registers. When it sees an output-immediate instruction, it emits a single-cycle event that carries the port number and the value the accumulator must hold.

Opcode fetches are told apart from refresh and operand reads by a per-opcode skip count. After each fetch, that many further memory reads are ignored. The two I/O-immediate opcodes use a skip of zero, so the host's own I/O handling takes over the cycles that follow them. Flags, the stack, alternate registers and full instruction decoding are not covered.

Top module: `shadow_tracker`

## Requirements
- R1: When reset is asserted (asynchronous, active low), all shadow registers, the skip counter and the previous-request flag are cleared and `io_wr_valid` is 0. An output instruction executed straight after reset reports data 0x00.
- R2: A cycle is an opcode fetch only when all of these hold: `mreq_n`=0, `wr_n`=1, `mreq_n` was 1 at the previous clock edge, and the skip counter is zero. Holding `mreq_n` low for a second edge does not produce a second fetch.
- R3: On a fetch, the skip counter loads the table value for the opcode. It decrements by one on each later edge with `mreq_n`=0 and `wr_n`=1 while it is nonzero. Edges with `mreq_n`=1 change neither the counter nor the shadows, so the refresh and operand reads it covers are never decoded.
- R4: The skip value is 1 for a one-byte opcode, 2 for a two-byte opcode (for example 0x3E, 0x06, 0x16, 0xE6) and 3 for a three-byte opcode (for example 0x21, 0x11). Opcodes 0xD3 and 0xDB use 0, so the next read cycle may itself be a fetch.
- R5: A fetch of 0xD3 raises `io_wr_valid` for exactly one clock, on the edge after the fetch edge. `io_wr_port` is the byte at fetch address+1, and `io_wr_data` is shadow A as it stood at the fetch.
- R6: Accumulator operations, all on 8 bits with wrap-around: 0x3E loads A from the byte at address+1, 0xAF clears A, 0x2F inverts A, 0x3C adds one, 0x3D subtracts one, 0xE6 ANDs A with the byte at address+1, and 0xF6 ORs A with the byte at address+1.
- R7: 0x78, 0x79, 0x7C and 0x7D copy shadow B, C, H and L into A. 0x7E loads A from the memory byte at address {H,L}.
- R8: 0x06 loads B from the byte at address+1, and 0x0E loads C the same way. 0x21 loads L from address+1 and H from address+2.
- R9: Any other opcode leaves every shadow register unchanged but still loads its skip count, so its operand bytes are not decoded.
- R10: There is no read strobe. A cycle with `mreq_n`=0 counts as a read when `wr_n`=1. A cycle with `wr_n`=0 is never a fetch and does not decrement the skip counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one bus sample per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mreq_n | input | 1 | Memory request strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 16 | Processor address bus |
| op_addr | output | 16 | Read-port address for the opcode byte |
| op_data | input | 8 | Memory byte at `op_addr` |
| arg1_addr | output | 16 | Read-port address for the first operand byte |
| arg1_data | input | 8 | Memory byte at `arg1_addr` |
| arg2_addr | output | 16 | Read-port address for the second operand byte |
| arg2_data | input | 8 | Memory byte at `arg2_addr` |
| hl_addr | output | 16 | Read-port address formed from shadow H and L |
| hl_data | input | 8 | Memory byte at `hl_addr` |
| io_wr_valid | output | 1 | One-cycle output-instruction event |
| io_wr_port | output | 8 | Port number of the event |
| io_wr_data | output | 8 | Shadow accumulator value of the event |

## Verification
The hardest situation to reach from the ports is a skip count that is off by one. Such an error only shows up as a refresh or operand read that is wrongly decoded. To expose it, every ignored read in the stimulus points at a memory byte holding 0xAF, which would clear A if it were ever decoded, and every instruction is followed by an output instruction that reports A. A write cycle is also placed inside a skip window, and operand bytes of untracked instructions are chosen to be tracked opcodes. Either mistake therefore shows up as a wrong accumulator value.

// File: rtl/shtrk_pkg.sv
package shtrk_pkg;

  localparam int unsigned BYTE_W = 8;
  localparam int unsigned SKIP_W = 2;
  localparam int unsigned NUM_OPS = 1 << BYTE_W;

  localparam logic [7:0] OP_OUT_N = 8'hD3;
  localparam logic [7:0] OP_IN_N  = 8'hDB;

  typedef struct packed {
    logic [7:0] a;
    logic [7:0] b;
    logic [7:0] c;
    logic [7:0] h;
    logic [7:0] l;
  } shadow_t;

  // Bus reads that follow the fetch of a given opcode (refresh plus operands).
  function automatic logic [SKIP_W-1:0] skip_of(input logic [7:0] op);
    logic [SKIP_W-1:0] s;
    s = SKIP_W'(1);
    if (op == OP_OUT_N || op == OP_IN_N)                          s = '0;
    else if (op[7:6] == 2'b00 && op[3:0] == 4'h1)                 s = SKIP_W'(3);
    else if (op == 8'h22 || op == 8'h2A || op == 8'h32 || op == 8'h3A) s = SKIP_W'(3);
    else if (op == 8'hC3 || op == 8'hCD)                          s = SKIP_W'(3);
    else if (op[7:6] == 2'b11 && (op[2:0] == 3'd2 || op[2:0] == 3'd4)) s = SKIP_W'(3);
    else if (op[7:6] == 2'b00 && op[2:0] == 3'd6)                 s = SKIP_W'(2);
    else if (op[7:6] == 2'b00 && op[2:0] == 3'd0 && op[5:3] >= 3'd2) s = SKIP_W'(2);
    else if (op[7:6] == 2'b11 && op[2:0] == 3'd6)                 s = SKIP_W'(2);
    return s;
  endfunction

endpackage

// File: rtl/shtrk_skip_rom.sv
module shtrk_skip_rom
  import shtrk_pkg::*;
(
  input  logic [7:0]        op,
  output logic [SKIP_W-1:0] skip
);

  logic [SKIP_W-1:0] rom [NUM_OPS];

  for (genvar i = 0; i < NUM_OPS; i++) begin : g_entry
    assign rom[i] = skip_of(8'(i));
  end

  assign skip = rom[op];

endmodule

// File: rtl/shtrk_fetch.sv
module shtrk_fetch
  import shtrk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mreq_act,
  input  logic              is_read,
  input  logic [SKIP_W-1:0] skip_load,
  output logic              fetch,
  output logic [SKIP_W-1:0] skip_q
);

  logic              prev_q, prev_d;
  logic [SKIP_W-1:0] skip_d;
  logic              rd_cyc;

  assign rd_cyc = mreq_act && is_read;

  always_comb begin
    fetch  = rd_cyc && !prev_q && (skip_q == '0);
    prev_d = mreq_act;
    skip_d = skip_q;
    if (fetch)
      skip_d = skip_load;
    else if (rd_cyc && skip_q != '0)
      skip_d = skip_q - SKIP_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      skip_q <= '0;
    end else begin
      prev_q <= prev_d;
      skip_q <= skip_d;
    end
  end

endmodule

// File: rtl/shtrk_shadow.sv
module shtrk_shadow
  import shtrk_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fetch,
  input  logic [7:0] op,
  input  logic [7:0] arg1,
  input  logic [7:0] arg2,
  input  logic [7:0] hl_byte,
  output shadow_t    sh_q,
  output logic       ev_valid,
  output logic [7:0] ev_port,
  output logic [7:0] ev_data
);

  shadow_t sh_d;
  logic    ev_fire;

  always_comb begin
    sh_d = sh_q;
    unique case (op)
      8'h3E: sh_d.a = arg1;
      8'hAF: sh_d.a = '0;
      8'h2F: sh_d.a = ~sh_q.a;
      8'h3C: sh_d.a = sh_q.a + 8'd1;
      8'h3D: sh_d.a = sh_q.a - 8'd1;
      8'hE6: sh_d.a = sh_q.a & arg1;
      8'hF6: sh_d.a = sh_q.a | arg1;
      8'h78: sh_d.a = sh_q.b;
      8'h79: sh_d.a = sh_q.c;
      8'h7C: sh_d.a = sh_q.h;
      8'h7D: sh_d.a = sh_q.l;
      8'h7E: sh_d.a = hl_byte;
      8'h06: sh_d.b = arg1;
      8'h0E: sh_d.c = arg1;
      8'h21: begin
        sh_d.l = arg1;
        sh_d.h = arg2;
      end
      default: ;
    endcase
  end

  assign ev_fire = fetch && (op == OP_OUT_N);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
    end else if (fetch) begin
      sh_q <= sh_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ev_valid <= 1'b0;
    end else begin
      ev_valid <= ev_fire;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ev_port <= '0;
      ev_data <= '0;
    end else if (ev_fire) begin
      ev_port <= arg1;
      ev_data <= sh_q.a;
    end
  end

endmodule

// File: rtl/shadow_tracker.sv
module shadow_tracker
  import shtrk_pkg::*;
#(
  parameter int unsigned ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mreq_n,
  input  logic              wr_n,
  input  logic [ADDR_W-1:0] addr,
  output logic [ADDR_W-1:0] op_addr,
  input  logic [7:0]        op_data,
  output logic [ADDR_W-1:0] arg1_addr,
  input  logic [7:0]        arg1_data,
  output logic [ADDR_W-1:0] arg2_addr,
  input  logic [7:0]        arg2_data,
  output logic [ADDR_W-1:0] hl_addr,
  input  logic [7:0]        hl_data,
  output logic              io_wr_valid,
  output logic [7:0]        io_wr_port,
  output logic [7:0]        io_wr_data
);

  logic              fetch;
  logic [SKIP_W-1:0] skip_load;
  logic [SKIP_W-1:0] skip_q;
  shadow_t           sh_q;
  logic [7:0]        a_q;

  assign op_addr   = addr;
  assign arg1_addr = addr + ADDR_W'(1);
  assign arg2_addr = addr + ADDR_W'(2);
  assign hl_addr   = ADDR_W'({sh_q.h, sh_q.l});
  assign a_q       = sh_q.a;

  shtrk_skip_rom u_rom (
    .op   (op_data),
    .skip (skip_load)
  );

  shtrk_fetch u_fetch (
    .clk       (clk),
    .rst_n     (rst_n),
    .mreq_act  (!mreq_n),
    .is_read   (wr_n),
    .skip_load (skip_load),
    .fetch     (fetch),
    .skip_q    (skip_q)
  );

  shtrk_shadow u_shadow (
    .clk      (clk),
    .rst_n    (rst_n),
    .fetch    (fetch),
    .op       (op_data),
    .arg1     (arg1_data),
    .arg2     (arg2_data),
    .hl_byte  (hl_data),
    .sh_q     (sh_q),
    .ev_valid (io_wr_valid),
    .ev_port  (io_wr_port),
    .ev_data  (io_wr_data)
  );

endmodule

// File: rtl/shtrk_chk.sv
module shtrk_chk
  import shtrk_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              mreq_n,
  input logic              wr_n,
  input logic              io_wr_valid,
  input logic [SKIP_W-1:0] skip_q,
  input logic [7:0]        a_q
);

  AST_EVT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    io_wr_valid |=> !io_wr_valid); // R5

  AST_SKIP_BLOCKS_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    (skip_q != '0) |=> !io_wr_valid); // R2

  AST_SKIP_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
    (!mreq_n && wr_n && skip_q != '0) |=> (skip_q == $past(skip_q) - SKIP_W'(1))); // R3

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    mreq_n |=> ($stable(skip_q) && $stable(a_q))); // R3

  AST_WRITE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!mreq_n && !wr_n) |=> ($stable(skip_q) && $stable(a_q))); // R10

endmodule

bind shadow_tracker shtrk_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .mreq_n      (mreq_n),
  .wr_n        (wr_n),
  .io_wr_valid (io_wr_valid),
  .skip_q      (skip_q),
  .a_q         (a_q)
);

// File: tb/sim_shadow_tracker.sv
module sim_shadow_tracker;

  logic        clk;
  logic        rst_n;
  logic        mreq_n;
  logic        wr_n;
  logic [15:0] addr;
  logic [15:0] op_addr, arg1_addr, arg2_addr, hl_addr;
  logic [7:0]  op_data, arg1_data, arg2_data, hl_data;
  logic        io_wr_valid;
  logic [7:0]  io_wr_port, io_wr_data;

  logic [7:0] mem [1024];

  assign op_data   = mem[op_addr[9:0]];
  assign arg1_data = mem[arg1_addr[9:0]];
  assign arg2_data = mem[arg2_addr[9:0]];
  assign hl_data   = mem[hl_addr[9:0]];

  shadow_tracker u0 (
    .clk(clk), .rst_n(rst_n), .mreq_n(mreq_n), .wr_n(wr_n), .addr(addr),
    .op_addr(op_addr), .op_data(op_data),
    .arg1_addr(arg1_addr), .arg1_data(arg1_data),
    .arg2_addr(arg2_addr), .arg2_data(arg2_data),
    .hl_addr(hl_addr), .hl_data(hl_data),
    .io_wr_valid(io_wr_valid), .io_wr_port(io_wr_port), .io_wr_data(io_wr_data)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int ev_cnt = 0;
  logic [7:0] ev_port = 8'h00;
  logic [7:0] ev_data = 8'h00;
  logic [15:0] pc = 16'h0000;
  localparam logic [15:0] TRAP = 16'h03F0;  // holds 0xAF

  always @(negedge clk) begin
    if (rst_n && io_wr_valid) begin
      ev_cnt  <= ev_cnt + 1;
      ev_port <= io_wr_port;
      ev_data <= io_wr_data;
    end
  end

  // {opcode, byte1, byte2, expected A reported by the following output}
  localparam int NV = 21;
  localparam logic [31:0] VEC [NV] = '{
    32'h3E5A_005A, // R6 load immediate
    32'h2F00_00A5, // R6 invert
    32'h3C00_00A6, // R6 increment
    32'h3D00_00A5, // R6 decrement
    32'hE60F_0005, // R6 and
    32'hF6C0_00C5, // R6 or
    32'hAF00_0000, // R6 clear
    32'h3D00_00FF, // R6 decrement wraps
    32'h3C00_0000, // R6 increment wraps
    32'h0612_0000, // R8 load B
    32'h7800_0012, // R7 copy B
    32'h0E34_0012, // R8 load C
    32'h7900_0034, // R7 copy C
    32'h2100_0334, // R8 load HL = 0x0300
    32'h7C00_0003, // R7 copy H
    32'h7D00_0000, // R7 copy L
    32'h7E00_009C, // R7 load from (HL)
    32'h163C_009C, // R9 untracked two-byte, operand looks like an increment
    32'h113E_AA9C, // R9 untracked three-byte, operands look like a load
    32'h4700_009C, // R9 untracked one-byte
    32'h7800_0012  // R9 B unchanged by the untracked opcode
  };
  localparam int VREQ [NV] = '{6,6,6,6,6,6,6,6,6,8,7,8,7,8,7,7,7,9,9,9,9};

  function automatic int ref_len(input logic [7:0] op);
    case (op)
      8'h3E, 8'hE6, 8'hF6, 8'h06, 8'h0E, 8'h16: return 2;
      8'h21, 8'h11: return 3;
      default: return 1;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_cycle(input logic [15:0] a, input logic w_n);
    @(negedge clk);
    addr = a; mreq_n = 1'b0; wr_n = w_n;
    @(negedge clk);
    mreq_n = 1'b1; wr_n = 1'b1;
  endtask

  task automatic exec(input logic [7:0] op, input logic [7:0] b1, input logic [7:0] b2);
    int n;
    n = ref_len(op);
    mem[pc[9:0]] = op; mem[pc[9:0] + 10'd1] = b1; mem[pc[9:0] + 10'd2] = b2;
    bus_cycle(pc, 1'b1);
    for (int k = 0; k < n; k++) bus_cycle(TRAP, 1'b1);
    pc = pc + 16'(n);
  endtask

  task automatic do_out(input logic [7:0] port, input logic [7:0] exp, input string tag);
    int c0;
    c0 = ev_cnt;
    mem[pc[9:0]] = 8'hD3; mem[pc[9:0] + 10'd1] = port;
    bus_cycle(pc, 1'b1);
    @(negedge clk);
    pc = pc + 16'd2;
    chk({tag, " event count"}, 8'(ev_cnt - c0), 8'd1);
    chk({tag, " port"}, ev_port, port);
    chk({tag, " data"}, ev_data, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int c0;
    for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
    mem[TRAP[9:0]] = 8'hAF;
    mem[10'h300]   = 8'h9C;
    rst_n = 1'b0; mreq_n = 1'b1; wr_n = 1'b1; addr = 16'h0000;
    repeat (3) @(negedge clk);
    chk("R1 valid in reset", {7'd0, io_wr_valid}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    do_out(8'h70, 8'h00, "R1 out after reset");

    for (int i = 0; i < NV; i++) begin
      exec(VEC[i][31:24], VEC[i][23:16], VEC[i][15:8]);
      do_out(8'h80 + 8'(i), VEC[i][7:0], $sformatf("R%0d vector %0d", VREQ[i], i));
    end

    // R4 / R5: output immediately followed by another output (skip zero)
    exec(8'h3E, 8'h21, 8'h00);
    do_out(8'h41, 8'h21, "R4 first out");
    do_out(8'h42, 8'h21, "R4 back-to-back out");

    // R2: request held low across two edges yields one fetch only
    c0 = ev_cnt;
    mem[pc[9:0]] = 8'hD3; mem[pc[9:0] + 10'd1] = 8'h55;
    @(negedge clk); addr = pc; mreq_n = 1'b0; wr_n = 1'b1;
    @(negedge clk);
    @(negedge clk); mreq_n = 1'b1;
    @(negedge clk);
    pc = pc + 16'd2;
    chk("R2 held request one event", 8'(ev_cnt - c0), 8'd1);
    chk("R5 held request port", ev_port, 8'h55);

    // R10 / R2: write cycle on an output opcode is not a fetch
    c0 = ev_cnt;
    mem[pc[9:0]] = 8'hD3; mem[pc[9:0] + 10'd1] = 8'h66;
    bus_cycle(pc, 1'b0);
    @(negedge clk);
    chk("R10 write cycle no event", 8'(ev_cnt - c0), 8'd0);
    pc = pc + 16'd2;

    // R10 / R3: write inside a skip window does not consume a skip
    mem[pc[9:0]] = 8'h3E; mem[pc[9:0] + 10'd1] = 8'h66;
    bus_cycle(pc, 1'b1);
    bus_cycle(TRAP, 1'b0);
    bus_cycle(TRAP, 1'b1);
    bus_cycle(TRAP, 1'b1);
    pc = pc + 16'd2;
    do_out(8'h43, 8'h66, "R10 write in skip window");

    // R1: reset in mid-run clears shadow A
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 valid during reset", {7'd0, io_wr_valid}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    do_out(8'h44, 8'h00, "R1 out after mid-run reset");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule